// File: doc/BRIEF.md
# Prescaled Table-Lookup Reciprocal Unit

This block returns an approximate reciprocal of an unsigned 14-bit fixed-point operand that has ten integer bits and four fraction bits. It is meant for the divide-by-reciprocal steps of a rasterizer datapath, such as edge-distance normalisation and gradient setup. In those steps a relative error of a few percent is invisible on screen, so a small lookup table can replace a divider.

Only 10 operand bits address the table. The unit counts the zeros in the top four operand bits, shifts the operand left by that count, and uses the upper ten bits of the result as an integer index. The table holds the reciprocal of every integer index as a hidden-one mantissa with six fraction bits and a negated exponent. The output exponent is the shift count minus the stored negated exponent. The result is registered, so it appears on the clock edge that accepts the operand. A zero operand raises an error flag.

Top module: `recip_unit`

## Requirements
- R1: An operand is accepted on a rising clock edge where `in_valid` is high. `out_valid` is high in the following cycle exactly when an operand was accepted at the previous edge, so a new operand may arrive every cycle.
- R2: The shift count m is the number of leading zeros in `in_data[13:10]`, capped at 4. The table index is bits [13:4] of `in_data` shifted left by m.
- R3: For index i ≥ 1, let k be the smallest integer with 2^k ≥ i. The six fraction bits `out_mant[5:0]` equal floor(2^(6+k)/i) − 64, and `out_mant[6]` is 1 for every non-zero operand.
- R4: `out_exp` is the 5-bit two's complement value m − k and lies between −10 and +4.
- R5: For every non-zero operand X, (out_mant/64)·2^out_exp is within 2% of 16/X.
- R6: A zero operand gives `out_err`=1, `out_mant`=7'h7F and `out_exp`=5'b01111. A non-zero operand gives `out_err`=0.
- R7: Operand 1 gives mantissa 7'h40 with exponent +4. Operand 16383 gives mantissa 7'h40 with exponent −10 (5'b10110).
- R8: While `in_valid` is low, `out_mant`, `out_exp` and `out_err` keep the values of the last result, whatever `in_data` carries.
- R9: While `rst_n` is low, and after its release until the first operand is accepted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 14 | Operand, unsigned, 10 integer and 4 fraction bits |
| out_valid | output | 1 | Result present this cycle |
| out_mant | output | 7 | Mantissa with explicit leading one, 1.6 format |
| out_exp | output | 5 | Result exponent, two's complement |
| out_err | output | 1 | Operand was zero |

## Verification
The handshake assertions assume that `in_valid` stays low for the two cycles in which the internal reset synchroniser releases. The bench keeps `in_valid` low through that window and for a few more cycles. The hold assertion assumes that nothing but an accepted operand may change the output fields. The bench therefore puts values that differ from the last operand on `in_data` during idle cycles, so the hold check is meaningful. The stimulus covers every non-zero code once, plus zero and directed corner codes, all delivered back to back.

// File: rtl/recip_pkg.sv
package recip_pkg;
  localparam int OP_W   = 14;  // operand width
  localparam int FRAC_W = 4;   // operand fraction bits
  localparam int IDX_W  = 10;  // table address width
  localparam int MF_W   = 6;   // stored mantissa fraction bits
  localparam int NE_W   = 4;   // stored negated exponent bits
  localparam int EXP_W  = 5;   // output exponent width

  // Table word for integer index idx: {negated exponent, mantissa fraction}.
  // Index 0 is unreachable and gets an all-ones word.
  function automatic int recip_entry(input int idx, input int mf_w, input int ne_w);
    int k;
    int q;
    if (idx == 0) begin
      return (((1 << ne_w) - 1) << mf_w) | ((1 << mf_w) - 1);
    end
    k = 0;
    for (int j = 0; j < 31; j++) begin
      if ((1 << j) < idx) k = j + 1;
    end
    q = (1 << (mf_w + k)) / idx;
    return (k << mf_w) | (q - (1 << mf_w));
  endfunction
endpackage

// File: rtl/recip_prescale.sv
module recip_prescale #(
  parameter int OP_W  = recip_pkg::OP_W,
  parameter int IDX_W = recip_pkg::IDX_W,
  localparam int PRE_BITS = OP_W - IDX_W,
  localparam int SH_W = $clog2(PRE_BITS + 1)
) (
  input  logic [OP_W-1:0]  op,
  output logic [SH_W-1:0]  shift,
  output logic [IDX_W-1:0] idx
);
  logic found;

  // leading-zero count over the top PRE_BITS bits, capped at PRE_BITS
  always_comb begin
    shift = SH_W'(PRE_BITS);
    found = 1'b0;
    for (int b = 0; b < PRE_BITS; b++) begin
      if (!found && op[OP_W-1-b]) begin
        shift = SH_W'(b);
        found = 1'b1;
      end
    end
  end

  assign idx = IDX_W'((op << shift) >> PRE_BITS);
endmodule

// File: rtl/recip_table.sv
module recip_table #(
  parameter int IDX_W = recip_pkg::IDX_W,
  parameter int MF_W  = recip_pkg::MF_W,
  parameter int NE_W  = recip_pkg::NE_W,
  localparam int DEPTH = 1 << IDX_W,
  localparam int ENT_W = MF_W + NE_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [MF_W-1:0]  frac,
  output logic [NE_W-1:0]  nexp
);
  logic [ENT_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = ENT_W'(recip_pkg::recip_entry(g, MF_W, NE_W));
  end

  assign {nexp, frac} = rom[idx];
endmodule

// File: rtl/recip_assemble.sv
module recip_assemble #(
  parameter int SH_W  = 3,
  parameter int MF_W  = recip_pkg::MF_W,
  parameter int NE_W  = recip_pkg::NE_W,
  parameter int EXP_W = recip_pkg::EXP_W
) (
  input  logic              is_zero,
  input  logic [SH_W-1:0]   shift,
  input  logic [NE_W-1:0]   nexp,
  input  logic [MF_W-1:0]   frac,
  output logic [MF_W:0]     mant,
  output logic [EXP_W-1:0]  expo,
  output logic              err
);
  always_comb begin
    if (is_zero) begin
      mant = '1;
      expo = {1'b0, {(EXP_W-1){1'b1}}};
      err  = 1'b1;
    end else begin
      mant = {1'b1, frac};
      expo = EXP_W'(shift) - EXP_W'(nexp);
      err  = 1'b0;
    end
  end
endmodule

// File: rtl/recip_unit.sv
module recip_unit #(
  parameter int OP_W  = recip_pkg::OP_W,
  parameter int IDX_W = recip_pkg::IDX_W,
  parameter int MF_W  = recip_pkg::MF_W,
  parameter int NE_W  = recip_pkg::NE_W,
  parameter int EXP_W = recip_pkg::EXP_W,
  localparam int PRE_BITS = OP_W - IDX_W,
  localparam int SH_W = $clog2(PRE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_data,
  output logic             out_valid,
  output logic [MF_W:0]    out_mant,
  output logic [EXP_W-1:0] out_exp,
  output logic             out_err
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  logic [SH_W-1:0]  shift;
  logic [IDX_W-1:0] idx;
  logic [MF_W-1:0]  frac;
  logic [NE_W-1:0]  nexp;
  logic [MF_W:0]    mant_d;
  logic [EXP_W-1:0] exp_d;
  logic             err_d;
  logic             valid_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  recip_prescale #(.OP_W(OP_W), .IDX_W(IDX_W)) i_pre (
    .op(in_data), .shift(shift), .idx(idx)
  );

  recip_table #(.IDX_W(IDX_W), .MF_W(MF_W), .NE_W(NE_W)) i_tbl (
    .idx(idx), .frac(frac), .nexp(nexp)
  );

  recip_assemble #(.SH_W(SH_W), .MF_W(MF_W), .NE_W(NE_W), .EXP_W(EXP_W)) i_asm (
    .is_zero(in_data == '0), .shift(shift), .nexp(nexp), .frac(frac),
    .mant(mant_d), .expo(exp_d), .err(err_d)
  );

  // next state
  always_comb begin
    valid_d = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_mant <= mant_d;
      out_exp  <= exp_d;
      out_err  <= err_d;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);  // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);  // R1
  AST_INDEX_LIVE: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_data != '0) |-> idx != '0);  // R2
  AST_SHIFT_NORM: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && shift < SH_W'(PRE_BITS)) |-> idx[IDX_W-1]);  // R2
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_err) |-> ($signed(out_exp) <= $signed(EXP_W'(PRE_BITS)) &&
                                 $signed(out_exp) >= $signed(EXP_W'(-IDX_W))));  // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_data == '0) |=> (out_err && out_mant == '1));  // R6
  AST_NONZERO_OK: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_data != '0) |=> (!out_err && out_mant[MF_W]));  // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !in_valid) |=> ($stable(out_mant) && $stable(out_exp) && $stable(out_err)));  // R8
endmodule

// File: tb/test_recip_unit.sv
module test_recip_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [13:0] in_data;
  logic        out_valid;
  logic [6:0]  out_mant;
  logic [4:0]  out_exp;
  logic        out_err;

  typedef struct {
    int         x;
    logic [6:0] mant;
    logic [4:0] expo;
    logic       err;
  } item_t;

  item_t sb[$];
  item_t last;
  int n_chk = 0;
  int n_fail = 0;
  bit pv = 1'b0;
  bit reported = 1'b0;

  recip_unit i_recip_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_mant(out_mant), .out_exp(out_exp), .out_err(out_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // expected value from the requirements
  function automatic item_t model(input int x);
    item_t r;
    int m, sh, idx, k;
    r.x = x;
    if (x == 0) begin
      r.mant = 7'h7F; r.expo = 5'b01111; r.err = 1'b1;
      return r;
    end
    m = 0;
    while (m < 4 && ((x >> (13 - m)) & 1) == 0) m++;
    sh  = (x << m) & 16'h3FFF;
    idx = sh >> 4;
    k = 0;
    while ((1 << k) < idx) k++;
    r.mant = 7'((1 << (6 + k)) / idx);
    r.expo = 5'(m - k);
    r.err  = 1'b0;
    return r;
  endfunction

  task automatic send(input int x);
    item_t e;
    e = model(x);
    sb.push_back(e);
    last = e;
    in_valid = 1'b1;
    in_data  = 14'(x);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_run(input int lo, input int hi);
    for (int x = lo; x <= hi; x++) begin
      item_t e;
      e = model(x);
      sb.push_back(e);
      last = e;
      in_valid = 1'b1;
      in_data  = 14'(x);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  always @(posedge clk) pv = in_valid;

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == pv, "R1", "out_valid", out_valid, pv);
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1", "result without operand, queue", 0, 1);
        end else begin
          item_t e;
          real ap, tr, rel;
          int se;
          e = sb.pop_front();
          chk(out_mant == e.mant, "R3", $sformatf("mantissa X=%0d", e.x), out_mant, e.mant);
          chk(out_exp == e.expo, "R4", $sformatf("exponent X=%0d", e.x), out_exp, e.expo);
          chk(out_err == e.err, "R6", $sformatf("error flag X=%0d", e.x), out_err, e.err);
          if (e.x == 1 || e.x == 16383) begin
            chk(out_mant == 7'h40 && out_exp == ((e.x == 1) ? 5'd4 : 5'b10110), "R7",
                $sformatf("corner X=%0d {mant,exp}", e.x), {out_mant, out_exp},
                {7'h40, (e.x == 1) ? 5'd4 : 5'b10110});
          end
          if (e.x != 0) begin
            ap = $itor(out_mant) / 64.0;
            se = $signed(out_exp);
            for (int i = 0; i < se; i++) ap = ap * 2.0;
            for (int i = 0; i < -se; i++) ap = ap / 2.0;
            tr = 16.0 / $itor(e.x);
            rel = (ap - tr) / tr;
            if (rel < 0.0) rel = -rel;
            chk(rel < 0.02, "R5", $sformatf("rel error ppm X=%0d", e.x),
                $rtoi(rel * 1.0e6), 20000);
          end
        end
      end
    end else begin
      chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after release", out_valid, 0);
    @(posedge clk); #1;

    // directed corners: R7 extremes, R6 zero, R2 shift counts 0..4
    send(1);
    send(16383);
    send(0);
    send(16);
    send(3);
    send(1024);
    send(1023);
    send(2048);
    send(8191);
    send(0);
    send(2730);
    repeat (3) @(posedge clk);
    #1;

    // R8: idle with changing in_data, outputs hold the last result
    for (int i = 0; i < 5; i++) begin
      in_data = 14'(5 + 777 * i);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid while idle", out_valid, 0);
      chk({out_mant, out_exp, out_err} == {last.mant, last.expo, last.err}, "R8",
          "held {mant,exp,err}", {out_mant, out_exp, out_err}, {last.mant, last.expo, last.err});
    end
    @(posedge clk); #1;

    // full sweep back to back, R2 R3 R4 R5
    send_run(1, 16383);
    repeat (4) @(posedge clk);
    #1;
    chk(sb.size() == 0, "R1", "results outstanding", sb.size(), 0);
    report();
    $finish;
  end
endmodule